// File: doc/BRIEF.md
# Iterative CORDIC Engine

This block is a word-parallel shift-and-add engine that evaluates rotation-family functions with one x, one y and one z adder-subtractor. The three adder-subtractors are reused on every clock of an operation. A one-cycle start request loads the initial words. A small controller then feeds the registered results back through the same adders for a fixed number of micro-rotations. At each step it picks the shift distance and the address of the angle constant. Afterwards the controller raises a one-cycle completion flag, and the final x, y and z stay on the outputs.

Two selects are latched at start. The first chooses the steering rule. In rotation, the sign of the angle accumulator steers each step, so z is driven to zero. In vectoring, the sign of y steers each step, so y is driven to zero. The second select chooses the coordinate system: circular, linear or hyperbolic. The system sets the weight of the cross term in the x update and which constant table the z branch reads. Hyperbolic operation starts at shift 1 and runs shifts 4 and 13 twice so that it converges. The engine applies no gain compensation. The circular gain (about 1.6468) and the hyperbolic gain (about 0.8282) remain in the x and y results. x and y carry two extra high-order bits for that growth.

Top module: `cordic_engine`

## Requirements
- R1: Circular rotation (mode_i=0, coord_i=2'b00): with z_i holding an angle θ in signed format with 13 fraction bits, x_o ≈ K·(x·cosθ − y·sinθ) and y_o ≈ K·(y·cosθ + x·sinθ). K = Π sqrt(1+2^-2i) for i = 0..13, and z_o ends near zero.
- R2: Circular vectoring (mode_i=1, coord_i=2'b00, x_i > 0): x_o ≈ K·sqrt(x²+y²), y_o ends near zero, and z_o ≈ z_i + atan(y_i/x_i).
- R3: Linear rotation (coord_i=2'b01, mode_i=0): x_o equals the sign-extended x_i exactly, y_o ≈ y_i + x_i·z, and z_o ends near zero.
- R4: Linear vectoring (coord_i=2'b01, mode_i=1): x_o equals x_i exactly, y_o ends near zero, and z_o ≈ z_i + y_i/x_i.
- R5: Hyperbolic rotation (coord_i=2'b10, mode_i=0): x_o ≈ Kh·(x·cosh z + y·sinh z) and y_o ≈ Kh·(y·cosh z + x·sinh z). Kh is the product of sqrt(1−2^-2i) over shifts 1..13, with shifts 4 and 13 taken twice. z_o ends near zero.
- R6: Hyperbolic vectoring (coord_i=2'b10, mode_i=1, x_i > |y_i|): x_o ≈ Kh·sqrt(x²−y²), y_o ends near zero, and z_o ≈ z_i + atanh(y_i/x_i).
- R7: done_o is high for exactly one cycle. It rises 14 clock edges after the edge that accepts start_i for circular and linear operations, and 15 edges after it for hyperbolic operations. busy_o is high from the edge after acceptance until done_o rises.
- R8: A start_i pulse while busy_o is high is ignored: the running operation keeps its timing and produces the results of its own inputs.
- R9: While idle and with start_i low, x_o, y_o and z_o hold their values, whatever the other inputs do.
- R10: While rst_ni is low, busy_o and done_o are 0 and x_o, y_o and z_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when busy_o is low |
| mode_i | input | 1 | 0 rotation, 1 vectoring |
| coord_i | input | 2 | 00 circular, 01 linear, 10 hyperbolic, 11 handled as linear |
| x_i | input | DATA_W (16) | Initial x, signed |
| y_i | input | DATA_W (16) | Initial y, signed |
| z_i | input | Z_W (16) | Initial angle or ratio, signed, Z_FRAC (13) fraction bits |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion flag |
| x_o | output | DATA_W+GUARD (18) | Final x, signed |
| y_o | output | DATA_W+GUARD (18) | Final y, signed |
| z_o | output | Z_W (16) | Final z, signed |

## Verification
The assertions check the control behaviour on every cycle. done_o is a single-cycle pulse that ends busy_o. The number of busy cycles matches the coordinate system latched at acceptance, and a start during busy does not restart that count. The outputs stay frozen while the engine is idle. The numerical results can only be shown by the bench's scenarios, which compare against closed-form real-valued functions with the gain applied. These cover each system in both modes with operands of both signs, the exact pass-through of x in linear mode, a start pulse fired mid-operation, and the reset values.

// File: rtl/cordic_pkg.sv
package cordic_pkg;
  typedef enum logic [1:0] {
    CRD_CIRC = 2'b00,
    CRD_LIN  = 2'b01,
    CRD_HYP  = 2'b10,
    CRD_RSV  = 2'b11
  } coord_e;

  typedef enum logic {
    OP_ROT = 1'b0,
    OP_VEC = 1'b1
  } op_e;
endpackage

// File: rtl/cordic_angle_rom.sv
module cordic_angle_rom
  import cordic_pkg::*;
#(
  parameter int Z_W    = 16,
  parameter int Z_FRAC = 13,
  parameter int ITER   = 14,
  parameter int IDX_W  = 4
) (
  input  coord_e                  coord_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic signed [Z_W-1:0]   angle_o
);
  function automatic real pow2n(int n);
    real r = 1.0;
    for (int k = 0; k < n; k++) r = r / 2.0;
    return r;
  endfunction

  // odd power series: alternating signs give atan, plain sum gives atanh
  function automatic real arc_series(real t, bit alt);
    real s = 0.0;
    real p = t;
    for (int k = 0; k < 40; k++) begin
      if (alt && (k % 2 == 1)) s = s - p / real'(2 * k + 1);
      else                     s = s + p / real'(2 * k + 1);
      p = p * t * t;
    end
    return s;
  endfunction

  function automatic logic signed [Z_W-1:0] to_fix(real v);
    real sc = 1.0;
    for (int k = 0; k < Z_FRAC; k++) sc = sc * 2.0;
    return Z_W'($rtoi(v * sc + 0.5));
  endfunction

  logic signed [Z_W-1:0] circ_tab [ITER];
  logic signed [Z_W-1:0] lin_tab  [ITER];
  logic signed [Z_W-1:0] hyp_tab  [ITER];

  for (genvar g = 0; g < ITER; g++) begin : g_tab
    localparam logic signed [Z_W-1:0] C_CIRC =
      (g == 0) ? to_fix(0.785398163397448) : to_fix(arc_series(pow2n(g), 1'b1));
    localparam logic signed [Z_W-1:0] C_LIN = to_fix(pow2n(g));
    localparam logic signed [Z_W-1:0] C_HYP =
      (g == 0) ? '0 : to_fix(arc_series(pow2n(g), 1'b0));
    assign circ_tab[g] = C_CIRC;
    assign lin_tab[g]  = C_LIN;
    assign hyp_tab[g]  = C_HYP;
  end

  always_comb begin
    angle_o = '0;
    if (int'(idx_i) < ITER) begin
      case (coord_i)
        CRD_CIRC: angle_o = circ_tab[idx_i];
        CRD_HYP:  angle_o = hyp_tab[idx_i];
        default:  angle_o = lin_tab[idx_i];
      endcase
    end
  end
endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl
  import cordic_pkg::*;
#(
  parameter int ITER  = 14,
  parameter int REP_A = 4,
  parameter int REP_B = 13,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  coord_e           coord_i,
  output logic             load_o,
  output logic             step_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o
);
  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e           state_q;
  logic [IDX_W-1:0] idx_q;
  logic             rep_q, hyp_q, done_q;
  logic             rep_pend, last_step;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);

  // hyperbolic: shifts REP_A and REP_B run a second time
  assign rep_pend  = hyp_q && !rep_q &&
                     ((idx_q == IDX_W'(REP_A)) || (idx_q == IDX_W'(REP_B)));
  assign last_step = step_o && !rep_pend && (idx_q == IDX_W'(ITER - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rep_q   <= 1'b0;
      hyp_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_step;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          hyp_q   <= (coord_i == CRD_HYP);
          idx_q   <= (coord_i == CRD_HYP) ? IDX_W'(1) : '0;
          rep_q   <= 1'b0;
        end
        default: begin
          if (rep_pend) begin
            rep_q <= 1'b1;
          end else if (last_step) begin
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            rep_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = step_o;
  assign done_o = done_q;
endmodule

// File: rtl/cordic_datapath.sv
module cordic_datapath
  import cordic_pkg::*;
#(
  parameter int XY_W  = 18,
  parameter int Z_W   = 16,
  parameter int IDX_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  step_i,
  input  coord_e                coord_i,
  input  op_e                   op_i,
  input  logic [IDX_W-1:0]      shift_i,
  input  logic signed [Z_W-1:0] angle_i,
  input  logic signed [XY_W-1:0] x_ld_i,
  input  logic signed [XY_W-1:0] y_ld_i,
  input  logic signed [Z_W-1:0] z_ld_i,
  output logic signed [XY_W-1:0] x_o,
  output logic signed [XY_W-1:0] y_o,
  output logic signed [Z_W-1:0] z_o
);
  logic signed [XY_W-1:0] x_q, y_q, x_n, y_n, xs, ys;
  logic signed [Z_W-1:0]  z_q, z_n;
  logic                   d_pos;

  // rotation steers on sign of z, vectoring on the negated sign of y
  assign d_pos = (op_i == OP_ROT) ? !z_q[Z_W-1] : y_q[XY_W-1];
  assign xs    = x_q >>> shift_i;
  assign ys    = y_q >>> shift_i;

  always_comb begin
    case (coord_i)
      CRD_CIRC: x_n = d_pos ? x_q - ys : x_q + ys;
      CRD_HYP:  x_n = d_pos ? x_q + ys : x_q - ys;
      default:  x_n = x_q;
    endcase
    y_n = d_pos ? y_q + xs : y_q - xs;
    z_n = d_pos ? z_q - angle_i : z_q + angle_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else if (load_i) begin
      x_q <= x_ld_i;
      y_q <= y_ld_i;
      z_q <= z_ld_i;
    end else if (step_i) begin
      x_q <= x_n;
      y_q <= y_n;
      z_q <= z_n;
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;
  assign z_o = z_q;
endmodule

// File: rtl/cordic_engine.sv
module cordic_engine
  import cordic_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GUARD  = 2,
  parameter int Z_W    = 16,
  parameter int Z_FRAC = 13,
  parameter int ITER   = 14,
  parameter int REP_A  = 4,
  parameter int REP_B  = 13,
  localparam int XY_W  = DATA_W + GUARD,
  localparam int IDX_W = $clog2(ITER)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    mode_i,
  input  logic [1:0]              coord_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] y_i,
  input  logic signed [Z_W-1:0]   z_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [XY_W-1:0]  x_o,
  output logic signed [XY_W-1:0]  y_o,
  output logic signed [Z_W-1:0]   z_o
);
  coord_e                coord_q;
  op_e                   op_q;
  logic                  load, step;
  logic [IDX_W-1:0]      idx;
  logic signed [Z_W-1:0] angle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coord_q <= CRD_CIRC;
      op_q    <= OP_ROT;
    end else if (load) begin
      coord_q <= coord_e'(coord_i);
      op_q    <= op_e'(mode_i);
    end
  end

  cordic_ctrl #(
    .ITER(ITER), .REP_A(REP_A), .REP_B(REP_B), .IDX_W(IDX_W)
  ) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .coord_i (coord_e'(coord_i)),
    .load_o  (load),
    .step_o  (step),
    .idx_o   (idx),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  cordic_angle_rom #(
    .Z_W(Z_W), .Z_FRAC(Z_FRAC), .ITER(ITER), .IDX_W(IDX_W)
  ) i_rom (
    .coord_i (coord_q),
    .idx_i   (idx),
    .angle_o (angle)
  );

  cordic_datapath #(
    .XY_W(XY_W), .Z_W(Z_W), .IDX_W(IDX_W)
  ) i_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step),
    .coord_i (coord_q),
    .op_i    (op_q),
    .shift_i (idx),
    .angle_i (angle),
    .x_ld_i  ({{GUARD{x_i[DATA_W-1]}}, x_i}),
    .y_ld_i  ({{GUARD{y_i[DATA_W-1]}}, y_i}),
    .z_ld_i  (z_i),
    .x_o     (x_o),
    .y_o     (y_o),
    .z_o     (z_o)
  );
endmodule

// File: rtl/cordic_engine_sva.sv
module cordic_engine_sva #(
  parameter int ITER = 14,
  parameter int XY_W = 18,
  parameter int Z_W  = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic [1:0]             coord_i,
  input logic                   busy_o,
  input logic                   done_o,
  input logic signed [XY_W-1:0] x_o,
  input logic signed [XY_W-1:0] y_o,
  input logic signed [Z_W-1:0]  z_o
);
  localparam int CNT_W = $clog2(ITER + 2) + 1;

  logic [CNT_W-1:0] run_cnt;
  logic             hyp_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt  <= '0;
      hyp_seen <= 1'b0;
    end else if (start_i && !busy_o) begin
      run_cnt  <= '0;
      hyp_seen <= (coord_i == 2'b10);
    end else if (busy_o) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_cnt == (hyp_seen ? CNT_W'(ITER + 1) : CNT_W'(ITER))));

  a_r8_busy_only_from_idle_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(start_i) && !$past(busy_o)));

  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(x_o) && $stable(y_o) && $stable(z_o)));
endmodule

bind cordic_engine cordic_engine_sva #(
  .ITER(ITER), .XY_W(XY_W), .Z_W(Z_W)
) i_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .coord_i (coord_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .x_o     (x_o),
  .y_o     (y_o),
  .z_o     (z_o)
);

// File: tb/test_cordic_engine.sv
`timescale 1ns/1ps
module test_cordic_engine;
  localparam int  ITER = 14;
  localparam real ZS   = 8192.0;
  localparam real TOL_XY = 24.0;
  localparam real TOL_Z  = 16.0;

  typedef struct packed {
    logic       op;
    logic [1:0] crd;
    int         x;
    int         y;
    int         z;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b00, 16000,     0,   6434},  // R1
    '{1'b0, 2'b00, 10000, -5000,  -9830},  // R1
    '{1'b1, 2'b00, 12000,  9000,      0},  // R2
    '{1'b1, 2'b00,  8000,-15000,   2048},  // R2
    '{1'b0, 2'b01, 12000,  1000,   6144},  // R3
    '{1'b0, 2'b01, -8000,   500, -10240},  // R3
    '{1'b1, 2'b01, 10000, 15000,      0},  // R4
    '{1'b1, 2'b01, 16000, -4000,   4096},  // R4
    '{1'b0, 2'b10, 10000,     0,   4096},  // R5
    '{1'b0, 2'b10, 12000,  3000,  -7373},  // R5
    '{1'b1, 2'b10, 12000,  6000,      0},  // R6
    '{1'b1, 2'b10, 10000, -3000,   1000}   // R6
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic [1:0] crd = 2'b00;
  logic signed [15:0] xi = '0, yi = '0, zi = '0;
  logic busy, done;
  logic signed [17:0] xo, yo;
  logic signed [15:0] zo;

  int  n_tests = 0, n_fail = 0;
  real k_circ, k_hyp;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  cordic_engine i_cordic_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .coord_i(crd),
    .x_i(xi), .y_i(yi), .z_i(zi), .busy_o(busy), .done_o(done),
    .x_o(xo), .y_o(yo), .z_o(zo)
  );

  task automatic chk_real(string req, string what, real act, real exp, real tol);
    real d = act - exp;
    n_tests++;
    if (d < 0.0) d = -d;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s %s: actual %f expected %f", req, what, act, exp);
    end
  endtask

  task automatic chk_int(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drives one operation and returns the edges from acceptance to done
  task automatic run_op(input vec_t v, output int lat);
    int cyc = 0;
    @(negedge clk);
    start = 1'b1; mode = v.op; crd = v.crd;
    xi = 16'(v.x); yi = 16'(v.y); zi = 16'(v.z);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R7 watchdog: actual no done expected done");
    end
    lat = cyc;
  endtask

  task automatic check_result(string req, vec_t v);
    real x = real'(v.x), y = real'(v.y), z = real'(v.z) / ZS;
    real ax = real'(xo), ay = real'(yo), az = real'(zo);
    if (v.crd == 2'b00 && !v.op) begin
      chk_real(req, "x", ax, k_circ * (x * $cos(z) - y * $sin(z)), TOL_XY);
      chk_real(req, "y", ay, k_circ * (y * $cos(z) + x * $sin(z)), TOL_XY);
      chk_real(req, "z", az, 0.0, TOL_Z);
    end else if (v.crd == 2'b00) begin
      chk_real(req, "x", ax, k_circ * $sqrt(x * x + y * y), TOL_XY);
      chk_real(req, "y", ay, 0.0, TOL_XY);
      chk_real(req, "z", az, (z + $atan(y / x)) * ZS, TOL_Z);
    end else if (v.crd == 2'b01 && !v.op) begin
      chk_int(req, "x exact", longint'(xo), longint'(v.x));
      chk_real(req, "y", ay, y + x * z, TOL_XY);
      chk_real(req, "z", az, 0.0, TOL_Z);
    end else if (v.crd == 2'b01) begin
      chk_int(req, "x exact", longint'(xo), longint'(v.x));
      chk_real(req, "y", ay, 0.0, TOL_XY);
      chk_real(req, "z", az, (z + y / x) * ZS, TOL_Z);
    end else if (!v.op) begin
      chk_real(req, "x", ax, k_hyp * (x * $cosh(z) + y * $sinh(z)), TOL_XY);
      chk_real(req, "y", ay, k_hyp * (y * $cosh(z) + x * $sinh(z)), TOL_XY);
      chk_real(req, "z", az, 0.0, TOL_Z);
    end else begin
      chk_real(req, "x", ax, k_hyp * $sqrt(x * x - y * y), TOL_XY);
      chk_real(req, "y", ay, 0.0, TOL_XY);
      chk_real(req, "z", az, (z + $atanh(y / x)) * ZS, TOL_Z);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R7 global watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int   lat;
    logic signed [17:0] hx, hy;
    logic signed [15:0] hz;
    vec_t a, b;

    k_circ = 1.0;
    for (int i = 0; i < ITER; i++) k_circ = k_circ * $sqrt(1.0 + $pow(2.0, -2.0 * i));
    k_hyp = 1.0;
    for (int i = 1; i < ITER; i++) begin
      k_hyp = k_hyp * $sqrt(1.0 - $pow(2.0, -2.0 * i));
      if (i == 4 || i == 13) k_hyp = k_hyp * $sqrt(1.0 - $pow(2.0, -2.0 * i));
    end

    // R10 reset state
    repeat (3) @(negedge clk);
    chk_int("R10", "busy", longint'(busy), 0);
    chk_int("R10", "done", longint'(done), 0);
    chk_int("R10", "x", longint'(xo), 0);
    chk_int("R10", "y", longint'(yo), 0);
    chk_int("R10", "z", longint'(zo), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      string req;
      req = $sformatf("R%0d", k / 2 + 1);
      run_op(VECS[k], lat);
      check_result(req, VECS[k]);
      // R7 latency and single-cycle done
      chk_int("R7", "latency", longint'(lat - 1),
              (VECS[k].crd == 2'b10) ? longint'(ITER + 1) : longint'(ITER));
      chk_int("R7", "busy at done", longint'(busy), 0);
      @(negedge clk);
      chk_int("R7", "done width", longint'(done), 0);
    end

    // R9 outputs hold while idle, inputs wiggling
    hx = xo; hy = yo; hz = zo;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      xi = 16'(k * 1234 - 5000); yi = 16'(-k * 777); zi = 16'(k * 321);
      mode = k[0]; crd = k[1:0];
    end
    @(negedge clk);
    chk_int("R9", "x hold", longint'(xo), longint'(hx));
    chk_int("R9", "y hold", longint'(yo), longint'(hy));
    chk_int("R9", "z hold", longint'(zo), longint'(hz));

    // R8 start during busy is ignored
    a = VECS[0];
    b = VECS[10];
    @(negedge clk);
    start = 1'b1; mode = a.op; crd = a.crd;
    xi = 16'(a.x); yi = 16'(a.y); zi = 16'(a.z);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (4) begin @(negedge clk); lat++; end
    start = 1'b1; mode = b.op; crd = b.crd;
    xi = 16'(b.x); yi = 16'(b.y); zi = 16'(b.z);
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk_int("R8", "latency unchanged", longint'(lat - 1), longint'(ITER));
    check_result("R8", a);
    @(negedge clk);
    chk_int("R8", "no second run", longint'(busy), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule